// File: doc/BRIEF.md
# Slave-Serial FPGA Configuration Loader

This block is a hardware master that loads a configuration bitstream into a downstream FPGA over its slave-serial port. A one-cycle `start` pulse begins a run. The loader drives the program line low for a fixed number of cycles and then releases it. It then waits for the device to release its init line. Once init is high, the loader takes bitstream bytes from a valid/ready byte stream and shifts each byte out MSB first on a data pin, with one configuration-clock pulse per bit. When every byte has gone out, it keeps pulsing the configuration clock until the device raises its done line. The result is reported as either `done_ok` or `error`.

The byte count is latched from `byte_len` at start, and the source marks the final byte with `in_last`. In reversed mode, chosen with `rev_mode` at start, the loader gathers four bytes at a time and sends them in the order 3,2,1,0, then 7,6,5,4, and so on. This suits images stored as little-endian 32-bit words. The device's init and done lines pass through two-flop synchronizers before any use.

Back-pressure rules on the byte stream:
- A byte is taken on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` depends only on the loader's own state, never on `in_valid`.
- `in_ready` stays low except during the data phase, and it drops once `byte_len` bytes have been taken.
- While a byte is not taken, the source must hold `in_data` and `in_last` steady.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset, `cfg_prog_n` is 1 and `cfg_clk`, `busy`, `done_ok`, `error` and `in_ready` are all 0.
- R2: A `start` taken while idle, with a valid length, drives `cfg_prog_n` low for exactly PROG_LOW clock cycles and raises `busy`. PROG_LOW must exceed the synchronizer depth of 2.
- R3: After the program line is released, the loader waits for the synchronized `cfg_init_n` to read 1. If it does not within INIT_TIMEOUT cycles, `error` is set, `busy` falls and no `cfg_clk` pulse is produced.
- R4: Each byte is sent MSB first. `cfg_dout` is valid before each rising edge of `cfg_clk`. `cfg_clk` stays high for HALF_PER cycles and low for at least HALF_PER cycles. `cfg_dout` does not change while `cfg_clk` is high.
- R5: Bytes are taken only on cycles with `in_valid` and `in_ready` both high. `in_ready` is 0 while the program line is low, while waiting for init, and once `byte_len` bytes have been taken.
- R6: With `rev_mode` = 1 at start, input byte i is transmitted in position i XOR 3. For example, input 0x10..0x17 goes out as 13,12,11,10,17,16,15,14.
- R7: A start with `byte_len` = 0, or with `rev_mode` = 1 and `byte_len` not a multiple of 4, sets `error` on the next cycle without pulsing the program line.
- R8: `in_last` must be 1 on the byte numbered `byte_len` and 0 on every other byte. Any mismatch sets `error` and ends the run.
- R9: After the final data bit, `cfg_clk` keeps pulsing until the synchronized `cfg_done` reads 1. The loader then sets `done_ok`.
- R10: If `cfg_done` stays low, exactly DONE_TIMEOUT extra `cfg_clk` pulses are produced and then `error` is set.
- R11: `done_ok` and `error` are never both 1. At the end of a run exactly one is set, and it holds until the next accepted start, which clears both. A `start` while `busy` is ignored.
- R12: While `busy` is 0, `cfg_clk` is 0 and `cfg_prog_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a run when idle |
| rev_mode | input | 1 | Reverse bytes within each group of 4, latched at start |
| byte_len | input | LEN_W | Number of bitstream bytes, latched at start |
| in_valid | input | 1 | Byte stream: data valid |
| in_data | input | 8 | Byte stream: data byte |
| in_last | input | 1 | Byte stream: marks the final byte |
| in_ready | output | 1 | Byte stream: loader can take a byte |
| cfg_prog_n | output | 1 | Active-low program line to the device |
| cfg_init_n | input | 1 | Active-low init line from the device (asynchronous) |
| cfg_clk | output | 1 | Configuration clock to the device |
| cfg_dout | output | 1 | Serial configuration data to the device |
| cfg_done | input | 1 | Done line from the device (asynchronous) |
| busy | output | 1 | A run is in progress |
| done_ok | output | 1 | Last run completed with done seen |
| error | output | 1 | Last run failed |

## Verification
The bound checker watches several port-level rules on every cycle:
- the result flags are never both set;
- the result flags hold while idle;
- exactly one flag is set when `busy` falls;
- `cfg_clk` is quiet and the program line is released whenever idle;
- `in_ready` stays low while the program line is low;
- the data pin stays still while the configuration clock is high.

Other rules can only be shown by the bench's scenarios. These are the transmitted byte order (plain and reversed), the program pulse width, the init and done timeouts, and the extra-clock count after the data. They also include rejection of bad lengths and a misplaced last marker, and the fact that a `start` during a run is ignored. The bench does this with a scoreboard that decodes the serial pin at each configuration-clock rise.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef enum logic [2:0] {
    LD_IDLE,
    LD_PROG,
    LD_WINIT,
    LD_DATA,
    LD_FLUSH
  } ld_state_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cfg_byte_order.sv
module cfg_byte_order #(
  parameter int GROUP = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       rev,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  input  logic       out_ready
);
  localparam int IW = (GROUP > 1) ? $clog2(GROUP) : 1;

  logic [7:0]    mem [GROUP];
  logic [IW-1:0] idx;
  logic          drain;

  assign in_ready  = !drain && !clr;
  assign out_valid = drain && !clr;
  assign out_data  = mem[idx];

  // storage: written in fill phase, no reset needed
  always_ff @(posedge clk)
    if (!drain && in_valid && in_ready) mem[idx] <= in_data;

  // fill upward, drain downward; plain mode uses slot 0 only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drain <= 1'b0;
      idx   <= '0;
    end else if (clr) begin
      drain <= 1'b0;
      idx   <= '0;
    end else if (!drain) begin
      if (in_valid && in_ready) begin
        if (!rev || idx == IW'(GROUP-1)) drain <= 1'b1;
        else                             idx   <= idx + 1'b1;
      end
    end else if (out_ready) begin
      if (idx == '0) drain <= 1'b0;
      else           idx   <= idx - 1'b1;
    end
  end
endmodule

// File: rtl/cfg_bit_serializer.sv
module cfg_bit_serializer #(
  parameter int HALF_PER = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       go,
  input  logic       pulse_only,
  input  logic [7:0] byte_in,
  output logic       idle,
  output logic       clk_lvl,
  output logic       dout
);
  localparam int HW = (HALF_PER > 1) ? $clog2(HALF_PER) : 1;

  logic          act;
  logic          hi;
  logic [HW-1:0] tmr;
  logic [3:0]    left;
  logic [7:0]    sh;

  assign idle    = !act;
  assign clk_lvl = hi;
  assign dout    = sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act  <= 1'b0;
      hi   <= 1'b0;
      tmr  <= '0;
      left <= '0;
      sh   <= '0;
    end else if (clr) begin
      act <= 1'b0;
      hi  <= 1'b0;
      tmr <= '0;
    end else if (!act) begin
      if (go) begin
        act  <= 1'b1;
        hi   <= 1'b0;
        tmr  <= '0;
        sh   <= pulse_only ? 8'hFF : byte_in;
        left <= pulse_only ? 4'd1 : 4'd8;
      end
    end else if (tmr == HW'(HALF_PER-1)) begin
      tmr <= '0;
      if (!hi) begin
        hi <= 1'b1;
      end else begin
        hi   <= 1'b0;
        sh   <= {sh[6:0], 1'b0};
        left <= left - 4'd1;
        if (left == 4'd1) act <= 1'b0;
      end
    end else begin
      tmr <= tmr + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_loader_pkg::*;
#(
  parameter int HALF_PER     = 2,
  parameter int PROG_LOW     = 4,
  parameter int INIT_TIMEOUT = 64,
  parameter int DONE_TIMEOUT = 16,
  parameter int LEN_W        = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rev_mode,
  input  logic [LEN_W-1:0] byte_len,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             in_ready,
  output logic             cfg_prog_n,
  input  logic             cfg_init_n,
  output logic             cfg_clk,
  output logic             cfg_dout,
  input  logic             cfg_done,
  output logic             busy,
  output logic             done_ok,
  output logic             error
);
  localparam int TMAX0 = (PROG_LOW > INIT_TIMEOUT) ? PROG_LOW : INIT_TIMEOUT;
  localparam int TMAX  = (TMAX0 > DONE_TIMEOUT) ? TMAX0 : DONE_TIMEOUT;
  localparam int TW    = $clog2(TMAX + 1);

  ld_state_t        st;
  logic [TW-1:0]    tmr;
  logic [LEN_W-1:0] len_q, in_cnt, out_cnt;
  logic             rev_q, ok_q, err_q;
  logic             init_s, done_s;

  logic       buf_in_ready, buf_out_valid, buf_out_ready;
  logic [7:0] buf_out_data;
  logic       ser_idle, ser_hi, ser_go, ser_pulse, clr;
  logic       acc, final_in, bad_len, flush_go;

  cfg_sync #(.W(2), .STAGES(2)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d ({cfg_done, cfg_init_n}),
    .q ({done_s, init_s})
  );

  assign clr      = (st == LD_IDLE);
  assign in_ready = buf_in_ready && (st == LD_DATA) && (in_cnt != len_q);
  assign acc      = in_valid && in_ready;
  assign final_in = (in_cnt == len_q - LEN_W'(1));
  assign bad_len  = (byte_len == '0) || (rev_mode && byte_len[1:0] != 2'b00);

  assign buf_out_ready = ser_idle && (st == LD_DATA) && (out_cnt != len_q);
  assign flush_go      = (st == LD_FLUSH) && ser_idle && !done_s
                         && (tmr != TW'(DONE_TIMEOUT));
  assign ser_pulse     = (st == LD_FLUSH);
  assign ser_go        = (buf_out_valid && buf_out_ready) || flush_go;

  cfg_byte_order #(.GROUP(4)) u_order (
    .clk (clk),
    .rst_n (rst_n),
    .clr (clr),
    .rev (rev_q),
    .in_valid (acc),
    .in_data (in_data),
    .in_ready (buf_in_ready),
    .out_valid (buf_out_valid),
    .out_data (buf_out_data),
    .out_ready (buf_out_ready)
  );

  cfg_bit_serializer #(.HALF_PER(HALF_PER)) u_ser (
    .clk (clk),
    .rst_n (rst_n),
    .clr (clr),
    .go (ser_go),
    .pulse_only (ser_pulse),
    .byte_in (buf_out_data),
    .idle (ser_idle),
    .clk_lvl (ser_hi),
    .dout (cfg_dout)
  );

  assign cfg_clk    = ser_hi && (st != LD_IDLE);
  assign cfg_prog_n = (st != LD_PROG);
  assign busy       = (st != LD_IDLE);
  assign done_ok    = ok_q;
  assign error      = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= LD_IDLE;
      tmr     <= '0;
      len_q   <= '0;
      in_cnt  <= '0;
      out_cnt <= '0;
      rev_q   <= 1'b0;
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (st)
        LD_IDLE: if (start) begin
          ok_q    <= 1'b0;
          err_q   <= 1'b0;
          len_q   <= byte_len;
          rev_q   <= rev_mode;
          in_cnt  <= '0;
          out_cnt <= '0;
          tmr     <= '0;
          if (bad_len) err_q <= 1'b1;
          else         st    <= LD_PROG;
        end
        LD_PROG: begin
          if (tmr == TW'(PROG_LOW-1)) begin
            tmr <= '0;
            st  <= LD_WINIT;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        LD_WINIT: begin
          if (init_s) begin
            tmr <= '0;
            st  <= LD_DATA;
          end else if (tmr == TW'(INIT_TIMEOUT-1)) begin
            err_q <= 1'b1;
            st    <= LD_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        LD_DATA: begin
          if (buf_out_valid && buf_out_ready) out_cnt <= out_cnt + 1'b1;
          if (out_cnt == len_q && ser_idle) begin
            tmr <= '0;
            st  <= LD_FLUSH;
          end
          if (acc) begin
            in_cnt <= in_cnt + 1'b1;
            if (in_last != final_in) begin
              err_q <= 1'b1;
              st    <= LD_IDLE;
            end
          end
        end
        LD_FLUSH: begin
          if (done_s) begin
            ok_q <= 1'b1;
            st   <= LD_IDLE;
          end else if (ser_idle) begin
            if (tmr == TW'(DONE_TIMEOUT)) begin
              err_q <= 1'b1;
              st    <= LD_IDLE;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
        end
        default: st <= LD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_serial_loader_chk.sv
module cfg_serial_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic in_ready,
  input logic cfg_prog_n,
  input logic cfg_clk,
  input logic cfg_dout,
  input logic busy,
  input logic done_ok,
  input logic error
);
  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_ok && error));

  a_r11_flags_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(done_ok) && $stable(error)));

  a_r11_one_result_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done_ok ^ error));

  a_r12_idle_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cfg_clk);

  a_r12_idle_prog_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cfg_prog_n);

  a_r5_no_ready_in_prog: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_prog_n |-> (!in_ready && !cfg_clk));

  a_r5_ready_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy);

  a_r4_dout_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_clk && $past(cfg_clk)) |-> $stable(cfg_dout));
endmodule

bind cfg_serial_loader cfg_serial_loader_chk u_chk (.*);

// File: tb/cfg_serial_loader_tb_top.sv
`timescale 1ns/1ps
module cfg_serial_loader_tb_top;
  localparam int HALF_PER = 2, PROG_LOW = 4, INIT_TIMEOUT = 64, DONE_TIMEOUT = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rev_mode = 1'b0;
  logic [15:0] byte_len = '0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, cfg_prog_n, cfg_clk, cfg_dout, busy, done_ok, error;
  logic cfg_init_n, cfg_done;

  // device model controls (driven by main only)
  logic init_hold = 1'b0;
  int   init_delay = 5;
  logic done_enable = 1'b0;
  int   done_after = 3;
  int   run_id = 1, run_base = 0, exp_total = 0;

  int checks = 0, errs = 0;
  // monitor-owned
  int pulses = 0, mon_checks = 0, mon_errs = 0, done_run = 0, prog_cycles = 0;
  logic [7:0] cur = '0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  cfg_serial_loader #(.HALF_PER(HALF_PER), .PROG_LOW(PROG_LOW),
    .INIT_TIMEOUT(INIT_TIMEOUT), .DONE_TIMEOUT(DONE_TIMEOUT), .LEN_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rev_mode(rev_mode), .byte_len(byte_len),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .cfg_prog_n(cfg_prog_n), .cfg_init_n(cfg_init_n), .cfg_clk(cfg_clk),
    .cfg_dout(cfg_dout), .cfg_done(cfg_done), .busy(busy), .done_ok(done_ok),
    .error(error));

  // device: init pulled low by program, released after a delay
  initial begin
    cfg_init_n = 1'b1;
    forever begin
      @(negedge cfg_prog_n);
      cfg_init_n <= 1'b0;
      @(posedge cfg_prog_n);
      if (!init_hold) begin
        repeat (init_delay) @(posedge clk);
        cfg_init_n <= 1'b1;
      end
    end
  end
  assign cfg_done = (done_run == run_id);

  always @(posedge clk) if (!cfg_prog_n) prog_cycles <= prog_cycles + 1;

  // scoreboard monitor: decode serial bytes at each rising cfg_clk
  always @(posedge cfg_clk) begin
    int rel;
    rel = pulses - run_base;
    pulses = pulses + 1;
    if (rel < 8*exp_total) begin
      cur = {cur[6:0], cfg_dout};
      if (rel % 8 == 7) begin
        mon_checks = mon_checks + 1;
        if (exp_q.size() == 0) begin
          mon_errs = mon_errs + 1;
          $display("FAIL R4 unexpected byte got %h exp none", cur);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          if (cur !== e) begin
            mon_errs = mon_errs + 1;
            $display("FAIL R4/R6 byte got %h exp %h", cur, e);
          end
        end
      end
    end else if (done_enable && (rel - 8*exp_total + 1) >= done_after) begin
      done_run <= run_id;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired act 1 exp 0");
    $display("CHECKS %0d ERRORS %0d", checks + mon_checks + 1, errs + mon_errs + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s act %0d exp %0d", req, what, act, exp);
    end
  endtask

  task automatic arm(input int total);
    run_id++;
    run_base = pulses;
    exp_total = total;
  endtask

  task automatic do_start(input int len, input bit rev);
    @(negedge clk);
    byte_len = 16'(len); rev_mode = rev; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic push_exp(input int len, input bit rev, input logic [7:0] base);
    for (int i = 0; i < len; i++) exp_q.push_back(base + 8'(rev ? (i ^ 3) : i));
  endtask

  // mid_start: index before which a start pulse is injected (-1 none)
  task automatic stream(input int nsend, input logic [7:0] base, input int lastpos, input int mid_start);
    for (int i = 0; i < nsend; i++) begin
      if (i == mid_start) begin start = 1'b1; byte_len = 16'd2; @(negedge clk); start = 1'b0; end
      in_valid = 1'b1; in_data = base + 8'(i); in_last = (i == lastpos);
      for (int g = 0; g < 2000 && !in_ready; g++) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      if (i % 3 == 1) repeat (2) @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 5000 && busy; g++) @(negedge clk);
  endtask

  task automatic wait_prog_release();
    for (int g = 0; g < 100 && cfg_prog_n; g++) @(negedge clk);
    for (int g = 0; g < 100 && !cfg_prog_n; g++) @(negedge clk);
  endtask

  initial begin
    int p0, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cfg_prog_n === 1'b1, "R1", "prog_n after reset", cfg_prog_n, 1);
    chk(cfg_clk === 1'b0, "R1", "cfg_clk after reset", cfg_clk, 0);
    chk(busy === 1'b0 && in_ready === 1'b0, "R1", "busy/ready after reset", busy, 0);
    chk(done_ok === 1'b0 && error === 1'b0, "R1", "flags after reset", error, 0);

    // A: plain order, done after 3 extra pulses
    done_enable = 1'b1; done_after = 3;
    arm(6); push_exp(6, 1'b0, 8'hA0);
    p0 = prog_cycles;
    do_start(6, 1'b0);
    chk(busy === 1'b1, "R2", "busy after start", busy, 1);
    wait_prog_release();
    chk(prog_cycles - p0 == PROG_LOW, "R2", "program low width", prog_cycles - p0, PROG_LOW);
    chk(in_ready === 1'b0 && busy === 1'b1, "R5", "ready low during init wait", in_ready, 0);
    stream(6, 8'hA0, 5, -1);
    chk(in_ready === 1'b0, "R5", "ready low after len bytes", in_ready, 0);
    wait_idle();
    chk(done_ok === 1'b1 && error === 1'b0, "R9", "done_ok after done seen", done_ok, 1);
    n = pulses - run_base - 48;
    chk(n >= 3 && n <= 5, "R9", "extra pulses before done", n, 3);
    chk(exp_q.size() == 0, "R4", "all bytes transmitted", exp_q.size(), 0);
    chk(cfg_clk === 1'b0 && cfg_prog_n === 1'b1, "R12", "idle pins", cfg_clk, 0);

    // B: reversed order with ignored start mid-run
    arm(8); push_exp(8, 1'b1, 8'h10);
    do_start(8, 1'b1);
    chk(done_ok === 1'b0 && error === 1'b0, "R11", "flags cleared by start", done_ok, 0);
    wait_prog_release();
    stream(8, 8'h10, 7, 3);
    wait_idle();
    chk(done_ok === 1'b1 && error === 1'b0, "R11", "start while busy ignored", done_ok, 1);
    chk(exp_q.size() == 0, "R6", "reversed bytes all sent", exp_q.size(), 0);
    repeat (10) @(negedge clk);
    chk(done_ok === 1'b1 && error === 1'b0, "R11", "done_ok holds", done_ok, 1);

    // C: bad lengths
    done_enable = 1'b0;
    arm(0); p0 = prog_cycles;
    do_start(6, 1'b1);
    chk(error === 1'b1 && busy === 1'b0, "R7", "rev len 6 rejected", error, 1);
    do_start(0, 1'b0);
    chk(error === 1'b1 && busy === 1'b0, "R7", "len 0 rejected", error, 1);
    chk(prog_cycles == p0, "R7", "no program pulse", prog_cycles - p0, 0);

    // D: misplaced last marker
    arm(0);
    do_start(4, 1'b0);
    wait_prog_release();
    stream(2, 8'h33, 1, -1);
    repeat (3) @(negedge clk);
    chk(error === 1'b1 && busy === 1'b0 && in_ready === 1'b0, "R8", "early last ends run", error, 1);

    // E: init never released
    init_hold = 1'b1;
    arm(0);
    do_start(4, 1'b0);
    wait_prog_release();
    n = 0;
    for (int g = 0; g < 500 && busy; g++) begin @(negedge clk); n++; end
    chk(error === 1'b1 && done_ok === 1'b0, "R3", "init timeout error", error, 1);
    chk(n >= INIT_TIMEOUT - 1 && n <= INIT_TIMEOUT + 1, "R3", "init wait length", n, INIT_TIMEOUT);
    chk(pulses == run_base, "R3", "no cfg_clk pulses", pulses - run_base, 0);
    init_hold = 1'b0;

    // F: done never rises
    arm(2); push_exp(2, 1'b0, 8'h5A);
    do_start(2, 1'b0);
    chk(error === 1'b0 && busy === 1'b1, "R11", "error cleared by start", error, 0);
    wait_prog_release();
    stream(2, 8'h5A, 1, -1);
    wait_idle();
    chk(error === 1'b1 && done_ok === 1'b0, "R10", "done timeout error", error, 1);
    chk(pulses - run_base - 16 == DONE_TIMEOUT, "R10", "extra pulse count",
        pulses - run_base - 16, DONE_TIMEOUT);
    chk(exp_q.size() == 0, "R4", "two bytes sent", exp_q.size(), 0);

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errs + mon_errs);
    $finish;
  end
endmodule